// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a slave on an I2C-compatible two-wire bus that exposes a small bank of 8-bit control registers to a bus master. The bus lines are sampled on the system clock: they pass through a two-flop synchroniser, and edge detection recovers clock edges and start and stop conditions. The slave never drives the data line high. It only asserts an open-drain pull-down enable. Clock stretching, general-call addressing and multi-master arbitration are not supported.

A write transaction begins with the device address. The first data byte after it loads the register pointer, and every later byte is stored at the pointer, which then advances. A read transaction returns bytes from wherever the pointer currently stands and advances it after each byte. The read ends when the master answers a byte with a not-acknowledge.

One bit of the 7-bit device address comes from a strap input, so two of these slaves can share a bus. After reset most registers are zero. Two exceptions exist: the four-byte subcarrier frequency word starts at 0x21F07C16, and mode register 0 starts with its pedestal-enable bit set.

Top module: `i2c_regslave`

## Requirements
- R1: While reset is asserted, register 0 (mode 0) reads 0x04, registers 4 to 7 read 0x16, 0x7C, 0xF0 and 0x21 (the subcarrier word 0x21F07C16, least significant byte at register 4), and every other register reads 0x00.
- R2: After a start condition (SDA falling while SCL is high), the slave shifts in 8 bits MSB first: a 7-bit address, then a direction bit (0 = write, 1 = read). On an address match it pulls SDA low for the whole ninth clock.
- R3: When the address does not match, the slave never drives SDA and changes no register until the next start condition.
- R4: In a write, the first data byte sets the register pointer and is acknowledged. Each later byte is acknowledged, stored at the pointer, and followed by a pointer increment.
- R5: The pointer uses the low log2(register count) bits of the pointer byte and wraps from the last register to register 0.
- R6: In a read, the slave sends the register at the current pointer MSB first, changing SDA only while SCL is low, and increments the pointer after each byte. The pointer persists between transactions.
- R7: A not-acknowledge from the master after a read byte ends the transfer. The slave then leaves SDA released until the next start condition.
- R8: A stop condition (SDA rising while SCL is high) returns the slave to idle and discards a partly received byte. A repeated start restarts the address phase.
- R9: The address is {0b01010, strap, 0}: 0x28 with the strap low and 0x2A with it high. Only the address selected by the current strap value is acknowledged.
- R10: A read transaction modifies no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| addr_strap_i | input | 1 | Strap that supplies address bit 1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| regs_o | output | NUM_REGS*8 | All register contents, register n at bits 8n+7:8n |

## Verification
The storing of a byte and the wrap of the pointer from the last register back to zero happen on the same clock edge. The bench provokes this by setting the pointer to 15 and writing two bytes, then judges it by reading register 15 and register 0 through the register outputs. A second collision comes from a stop condition that arrives while a data byte is only half shifted in. The bench provokes it by sending four bits and then a stop, and judges it by confirming that the target register keeps its old value and that a complete write to it afterwards succeeds.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_PTR,
    ST_PACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK
  } st_e;

  localparam logic [7:0]  MODE0_RST = 8'h04;
  localparam logic [31:0] SCF_RST   = 32'h21F07C16;

  function automatic logic [7:0] reg_reset_value(int idx, int mode_idx, int scf_base);
    if (idx == mode_idx) return MODE0_RST;
    if (idx >= scf_base && idx < scf_base + 4) return SCF_RST[8*(idx-scf_base) +: 8];
    return 8'h00;
  endfunction

endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  // bit 1 = SCL, bit 0 = SDA; idle bus is high
  logic [STAGES-1:0][1:0] chain_q;
  logic [1:0]             prev_q;
  logic [1:0]             line;

  assign line = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 2'b11;
    end else begin
      chain_q[0] <= {scl_i, sda_i};
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= line;
    end
  end

  assign sda_s     = line[0];
  assign scl_rise  = line[1] & ~prev_q[1];
  assign scl_fall  = ~line[1] & prev_q[1];
  assign start_det = line[1] & prev_q[1] & prev_q[0] & ~line[0];
  assign stop_det  = line[1] & prev_q[1] & ~prev_q[0] & line[0];

endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto import i2cr_pkg::*; #(
  parameter int         PTR_W    = 4,
  parameter logic [6:0] DEV_ADDR = 7'h28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             strap,
  input  logic [7:0]       rd_data,
  output logic [PTR_W-1:0] ptr,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic             sda_oe,
  output logic             rw,
  output st_e              state
);

  st_e              state_q, state_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             oe_q, oe_d;
  logic             phase_q, phase_d;
  logic             rw_q, rw_d;
  logic [6:0]       my_addr;
  logic [7:0]       rx_byte;

  assign my_addr = {DEV_ADDR[6:2], strap, DEV_ADDR[0]};
  assign rx_byte = {sh_q[6:0], sda_s};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    oe_d    = oe_q;
    phase_d = phase_q;
    rw_d    = rw_q;
    wr_en   = 1'b0;
    if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
      phase_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = rx_byte;
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              phase_d = 1'b0;
              if (state_q == ST_ADDR) begin
                if (rx_byte[7:1] == my_addr) begin
                  rw_d    = rx_byte[0];
                  state_d = ST_AACK;
                end else begin
                  state_d = ST_IDLE;
                end
              end else if (state_q == ST_PTR) begin
                ptr_d   = rx_byte[PTR_W-1:0];
                state_d = ST_PACK;
              end else begin
                wr_en   = 1'b1;
                ptr_d   = ptr_q + 1'b1;
                state_d = ST_WACK;
              end
            end
          end
        end
        ST_AACK, ST_PACK, ST_WACK: begin
          if (scl_fall) begin
            if (!phase_q) begin
              oe_d    = 1'b1;
              phase_d = 1'b1;
            end else begin
              phase_d = 1'b0;
              cnt_d   = '0;
              if (state_q == ST_AACK && rw_q) begin
                sh_d    = rd_data;
                oe_d    = ~rd_data[7];
                state_d = ST_RDATA;
              end else begin
                oe_d    = 1'b0;
                state_d = (state_q == ST_AACK) ? ST_PTR : ST_WDATA;
              end
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            oe_d = ~sh_q[6];
            sh_d = {sh_q[6:0], 1'b0};
          end
          if (scl_rise) begin
            cnt_d = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              ptr_d   = ptr_q + 1'b1;
              phase_d = 1'b0;
              state_d = ST_RACK;
            end
          end
        end
        ST_RACK: begin
          if (!phase_q) begin
            if (scl_fall) begin
              oe_d    = 1'b0;
              phase_d = 1'b1;
              cnt_d   = '0;
            end
          end else if (scl_rise) begin
            if (sda_s) state_d = ST_IDLE;
            else       cnt_d   = 3'd1;
          end else if (scl_fall && cnt_q == 3'd1) begin
            sh_d    = rd_data;
            oe_d    = ~rd_data[7];
            cnt_d   = '0;
            phase_d = 1'b0;
            state_d = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      phase_q <= 1'b0;
      rw_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      oe_q    <= oe_d;
      phase_q <= phase_d;
      rw_q    <= rw_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_data = rx_byte;
  assign sda_oe  = oe_q;
  assign rw      = rw_q;
  assign state   = state_q;

endmodule

// File: rtl/i2cr_regfile.sv
module i2cr_regfile import i2cr_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int PTR_W    = 4,
  parameter int MODE_IDX = 0,
  parameter int SCF_BASE = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      addr,
  input  logic [7:0]            wr_data,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST = reg_reset_value(g, MODE_IDX, SCF_BASE);
    logic [7:0] q;
    logic       we;
    assign we = wr_en && (addr == PTR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= wr_data;
    end
    assign regs_flat[g*8 +: 8] = q;
  end

  assign rd_data = regs_flat[{addr, 3'b000} +: 8];

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave import i2cr_pkg::*; #(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h28,
  parameter int         MODE_IDX    = 0,
  parameter int         SCF_BASE    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic                  addr_strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  localparam int PTR_W = $clog2(NUM_REGS);

  logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [PTR_W-1:0] ptr;
  logic             wr_en, rw;
  logic [7:0]       wr_data, rd_data;
  st_e              state;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cr_proto #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) u_proto (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(addr_strap_i), .rd_data(rd_data), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .sda_oe(sda_oe_o), .rw(rw), .state(state)
  );

  i2cr_regfile #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W), .MODE_IDX(MODE_IDX),
                 .SCF_BASE(SCF_BASE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(ptr), .wr_data(wr_data),
    .rd_data(rd_data), .regs_flat(regs_o)
  );

endmodule

// File: rtl/i2cr_checker.sv
module i2cr_checker import i2cr_pkg::*; #(
  parameter int NUM_REGS = 16,
  parameter int MODE_IDX = 0,
  parameter int SCF_BASE = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input st_e                   state,
  input logic                  sda_oe,
  input logic                  start_det,
  input logic                  stop_det,
  input logic                  scl_fall,
  input logic                  wr_en,
  input logic                  rw,
  input logic [NUM_REGS*8-1:0] regs
);

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_values: assert (regs[MODE_IDX*8 +: 8] == MODE0_RST &&
                                 regs[SCF_BASE*8 +: 32] == SCF_RST)
        else $error("R1 reset defaults wrong");
    end
  end

  a_r2_start_enters_addr: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> state == ST_ADDR);

  a_r3_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_oe);

  a_r4_write_in_data_phase: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> state == ST_WDATA);

  a_r6_drive_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  a_r8_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state == ST_IDLE);

  a_r10_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    rw |-> !wr_en);

endmodule

bind i2c_regslave i2cr_checker #(.NUM_REGS(NUM_REGS), .MODE_IDX(MODE_IDX),
                                 .SCF_BASE(SCF_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .sda_oe(sda_oe_o),
  .start_det(start_det), .stop_det(stop_det), .scl_fall(scl_fall),
  .wr_en(wr_en), .rw(rw), .regs(regs_o)
);

// File: tb/i2c_regslave_tb.sv
module i2c_regslave_tb;

  localparam int NREG = 16;
  localparam int H    = 6;

  logic clk, rst_n, scl, sda_m, strap;
  logic sda_oe;
  logic sda_bus;
  logic [NREG*8-1:0] regs;

  assign sda_bus = sda_m & ~sda_oe;

  i2c_regslave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct { string tag; logic [7:0] val; } item_t;
  item_t      exp_q[$];
  logic [7:0] act_q[$];
  int  checks = 0;
  int  errors = 0;
  bit  done   = 0;

  task automatic expect_item(string tag, logic [7:0] v);
    item_t it;
    it.tag = tag; it.val = v;
    exp_q.push_back(it);
  endtask

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_h();
    scl   = 1'b1; wait_h();
    sda_m = 1'b0; wait_h();
    scl   = 1'b0; wait_h();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_h();
    scl   = 1'b1; wait_h();
    sda_m = 1'b1; wait_h();
  endtask

  task automatic send_bit(logic b);
    sda_m = b; wait_h();
    scl   = 1'b1; wait_h();
    scl   = 1'b0; wait_h();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; wait_h();
    scl   = 1'b1; wait_h();
    b     = sda_bus;
    scl   = 1'b0; wait_h();
  endtask

  // exp_nack = 0: slave acknowledge expected (line low)
  task automatic wr_byte(string tag, logic [7:0] b, logic exp_nack);
    logic a;
    expect_item(tag, {7'd0, exp_nack});
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    act_q.push_back({7'd0, a});
  endtask

  task automatic rd_byte(string tag, logic [7:0] exp_v, logic m_ack);
    logic [7:0] v;
    logic b;
    expect_item(tag, exp_v);
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      v[i] = b;
    end
    act_q.push_back(v);
    send_bit(~m_ack);
  endtask

  task automatic check_reg(string tag, int idx, logic [7:0] v);
    expect_item(tag, v);
    @(negedge clk);
    act_q.push_back(regs[idx*8 +: 8]);
  endtask

  // monitor: pops observations and compares with scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0) begin
        logic [7:0] a;
        item_t e;
        a = act_q.pop_front();
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL unexpected observation: actual=%02h expected=none", a);
        end else begin
          e = exp_q.pop_front();
          if (a !== e.val) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", e.tag, a, e.val);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] scf [4];
    scf[0] = 8'h16; scf[1] = 8'h7C; scf[2] = 8'hF0; scf[3] = 8'h21;
    rst_n = 1'b1; scl = 1'b1; sda_m = 1'b1; strap = 1'b0;
    #2 rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1: defaults observed while reset is held
    for (int i = 0; i < NREG; i++) begin
      if (i == 0)                check_reg("R1", i, 8'h04);
      else if (i >= 4 && i < 8)  check_reg("R1", i, scf[i-4]);
      else                       check_reg("R1", i, 8'h00);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 R4: pointer then two data bytes
    bus_start();
    wr_byte("R2", 8'h50, 1'b0);
    wr_byte("R4", 8'h02, 1'b0);
    wr_byte("R4", 8'hA5, 1'b0);
    wr_byte("R4", 8'h3C, 1'b0);
    bus_stop();
    check_reg("R4", 2, 8'hA5);
    check_reg("R4", 3, 8'h3C);
    check_reg("R4", 4, 8'h16);
    bus_start();
    wr_byte("R4", 8'h50, 1'b0);
    wr_byte("R4", 8'h08, 1'b0);
    wr_byte("R4", 8'h99, 1'b0);
    bus_stop();
    check_reg("R4", 8, 8'h99);

    // R3: foreign address ignored
    bus_start();
    wr_byte("R3", 8'h60, 1'b1);
    wr_byte("R3", 8'h00, 1'b1);
    wr_byte("R3", 8'hEE, 1'b1);
    bus_stop();
    check_reg("R3", 0, 8'h04);

    // R9 + R5: strap moves the address; pointer wrap on write
    strap = 1'b1;
    bus_start();
    wr_byte("R9", 8'h50, 1'b1);
    bus_stop();
    bus_start();
    wr_byte("R9", 8'h54, 1'b0);
    wr_byte("R5", 8'h0F, 1'b0);
    wr_byte("R5", 8'h11, 1'b0);
    wr_byte("R5", 8'h22, 1'b0);
    bus_stop();
    check_reg("R5", 15, 8'h11);
    check_reg("R5", 0, 8'h22);
    strap = 1'b0;

    // R6 R7 R8: set pointer, repeated start, burst read ending in NACK
    bus_start();
    wr_byte("R8", 8'h50, 1'b0);
    wr_byte("R6", 8'h03, 1'b0);
    bus_start();
    wr_byte("R8", 8'h51, 1'b0);
    rd_byte("R6", 8'h3C, 1'b1);
    rd_byte("R6", 8'h16, 1'b1);
    rd_byte("R6", 8'h7C, 1'b1);
    rd_byte("R6", 8'hF0, 1'b1);
    rd_byte("R6", 8'h21, 1'b0);
    rd_byte("R7", 8'hFF, 1'b0);
    bus_stop();

    // R6: pointer persisted at 8
    bus_start();
    wr_byte("R6", 8'h51, 1'b0);
    rd_byte("R6", 8'h99, 1'b0);
    bus_stop();
    check_reg("R10", 3, 8'h3C);
    check_reg("R10", 4, 8'h16);
    check_reg("R10", 7, 8'h21);
    check_reg("R10", 8, 8'h99);

    // R8: stop inside a data byte discards it
    bus_start();
    wr_byte("R8", 8'h50, 1'b0);
    wr_byte("R8", 8'h0C, 1'b0);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    check_reg("R8", 12, 8'h00);
    bus_start();
    wr_byte("R8", 8'h50, 1'b0);
    wr_byte("R8", 8'h0C, 1'b0);
    wr_byte("R8", 8'h77, 1'b0);
    bus_stop();
    check_reg("R8", 12, 8'h77);

    repeat (4) @(negedge clk);
    while (act_q.size() > 0) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule